// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM burst. A load strobe captures a starting column, a bank select, a burst-length code and an ordering bit. From the next clock onward, the block presents one column address per beat. The address moves to the next beat on each cycle in which the advance enable is high.

Only the low three column bits change during a burst. The field that changes is log2 of the burst length wide, and it wraps inside the aligned burst boundary. The column bits above that field stay as they were loaded. The ordering is either sequential, which counts modulo the burst length, or interleaved, where beat i is the start offset XOR i. A valid flag marks an active burst, and a last flag marks its final beat. A new load at any time restarts the sequence.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and after it is released, and before any load, `valid_o` and `last_o` are 0 and `col_o` and `bank_o` are 0.
- R2: A load sampled at a rising edge makes `valid_o` 1 from that edge on. `col_o` then equals the loaded start column (beat 0). `bank_o` equals the loaded bank and holds until the next load.
- R3: With `order_i` = 0 (sequential), beat i shows the start column's low log2(L) bits plus i, modulo L.
- R4: With `order_i` = 1 (interleaved), beat i shows the start column's low log2(L) bits XOR i.
- R5: `len_code_i` selects the burst length L: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. Column bits at or above position log2(L) never change during a burst.
- R6: While a burst is valid and `adv_i` is 0 with no load, `col_o`, `last_o` and `valid_o` hold.
- R7: `last_o` is 1 exactly on beat L-1 of a valid burst. An advance on that beat clears `valid_o` at the next edge.
- R8: A load during a burst takes priority over advance and restarts at beat 0 with the newly loaded parameters.
- R9: While no burst is valid, `adv_i` has no effect: `valid_o` stays 0 until a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture start column, bank, length and order |
| start_col_i | input | COL_W (9) | Starting column address |
| bank_i | input | BANK_W (1) | Bank select |
| len_code_i | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:8) |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| adv_i | input | 1 | Step to the next beat |
| col_o | output | COL_W (9) | Column address of the current beat |
| bank_o | output | BANK_W (1) | Bank of the current burst |
| valid_o | output | 1 | A burst is active |
| last_o | output | 1 | Current beat is the final one |

## Verification
All outputs come directly from registered state, so a corrupted beat index or stored mask is visible on `col_o` or `last_o` in the same cycle the state goes wrong. A wrong mask shows up in two ways. Column bits above the burst field move, or the last flag lands on the wrong beat; either way `valid_o` ends the burst early or late within one advance. The bench compares every output on every cycle against a reference model. Because of that, such a fault is reported at the first beat where it diverges, not at the end of the burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
    // burst ordering selector
    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } burst_order_e;

    // burst length codes: length = 2**code
    localparam logic [1:0] LEN_ONE   = 2'd0;
    localparam logic [1:0] LEN_TWO   = 2'd1;
    localparam logic [1:0] LEN_FOUR  = 2'd2;
    localparam logic [1:0] LEN_EIGHT = 2'd3;
endpackage

// File: rtl/burst_span_dec.sv
// Turns a length code into a mask of the column bits that vary in a burst.
module burst_span_dec #(
    parameter int LOW_W  = 3,
    parameter int CODE_W = 2
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [LOW_W-1:0]  mask_o
);
    for (genvar g = 0; g < LOW_W; g++) begin : g_bit
        // bit g varies when the burst spans more than 2**g beats
        assign mask_o[g] = (int'(code_i) > g);
    end
endmodule

// File: rtl/burst_offset_gen.sv
// Forms the column address of a beat from the start column, beat index,
// span mask and ordering.
module burst_offset_gen
    import burst_pkg::*;
#(
    parameter int COL_W = 9,
    parameter int LOW_W = 3
) (
    input  logic [COL_W-1:0] start_i,
    input  logic [LOW_W-1:0] beat_i,
    input  logic [LOW_W-1:0] mask_i,
    input  burst_order_e     order_i,
    output logic [COL_W-1:0] col_o
);
    localparam int HI_W = COL_W - LOW_W;

    logic [LOW_W-1:0] seq_low;
    logic [LOW_W-1:0] xor_low;
    logic [LOW_W-1:0] pick_low;
    logic [LOW_W-1:0] keep_low;

    always_comb begin
        seq_low  = start_i[LOW_W-1:0] + beat_i;
        xor_low  = start_i[LOW_W-1:0] ^ beat_i;
        pick_low = (order_i == ORD_XOR) ? xor_low : seq_low;
        keep_low = (start_i[LOW_W-1:0] & ~mask_i) | (pick_low & mask_i);
        col_o    = {start_i[COL_W-1:LOW_W], keep_low};
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = '0;
endmodule

// File: rtl/burst_seq_ctrl.sv
// Holds the burst context and steps the beat index.
module burst_seq_ctrl
    import burst_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int BANK_W = 1,
    parameter int LOW_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [COL_W-1:0]  start_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [LOW_W-1:0]  mask_i,
    input  burst_order_e      order_i,
    output logic              valid_o,
    output logic              last_o,
    output logic [LOW_W-1:0]  beat_o,
    output logic [LOW_W-1:0]  mask_o,
    output logic [COL_W-1:0]  start_o,
    output logic [BANK_W-1:0] bank_o,
    output burst_order_e      order_o
);
    typedef struct packed {
        logic              valid;
        logic [LOW_W-1:0]  beat;
        logic [LOW_W-1:0]  mask;
        logic [COL_W-1:0]  start;
        logic [BANK_W-1:0] bank;
        burst_order_e      order;
    } ctx_t;

    ctx_t ctx_d, ctx_q;
    logic at_end;

    always_comb begin
        at_end = ctx_q.valid && (ctx_q.beat == ctx_q.mask);
        ctx_d  = ctx_q;
        if (load_i) begin
            ctx_d.valid = 1'b1;
            ctx_d.beat  = '0;
            ctx_d.mask  = mask_i;
            ctx_d.start = start_i;
            ctx_d.bank  = bank_i;
            ctx_d.order = order_i;
        end else if (ctx_q.valid && adv_i) begin
            if (at_end) begin
                ctx_d.valid = 1'b0;
            end else begin
                ctx_d.beat = ctx_q.beat + LOW_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign valid_o = ctx_q.valid;
    assign last_o  = at_end;
    assign beat_o  = ctx_q.beat;
    assign mask_o  = ctx_q.mask;
    assign start_o = ctx_q.start;
    assign bank_o  = ctx_q.bank;
    assign order_o = ctx_q.order;
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import burst_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int BANK_W = 1,
    parameter int LOW_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [1:0]        len_code_i,
    input  logic              order_i,
    input  logic              adv_i,
    output logic [COL_W-1:0]  col_o,
    output logic [BANK_W-1:0] bank_o,
    output logic              valid_o,
    output logic              last_o
);
    localparam int CODE_W = 2;

    logic [LOW_W-1:0] new_mask;
    logic [LOW_W-1:0] cur_mask;
    logic [LOW_W-1:0] cur_beat;
    logic [COL_W-1:0] cur_start;
    burst_order_e     cur_order;
    burst_order_e     in_order;

    assign in_order = burst_order_e'(order_i);

    burst_span_dec #(.LOW_W(LOW_W), .CODE_W(CODE_W)) u_span (
        .code_i (len_code_i),
        .mask_o (new_mask)
    );

    burst_seq_ctrl #(.COL_W(COL_W), .BANK_W(BANK_W), .LOW_W(LOW_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_i   (adv_i),
        .start_i (start_col_i),
        .bank_i  (bank_i),
        .mask_i  (new_mask),
        .order_i (in_order),
        .valid_o (valid_o),
        .last_o  (last_o),
        .beat_o  (cur_beat),
        .mask_o  (cur_mask),
        .start_o (cur_start),
        .bank_o  (bank_o),
        .order_o (cur_order)
    );

    burst_offset_gen #(.COL_W(COL_W), .LOW_W(LOW_W)) u_off (
        .start_i (cur_start),
        .beat_i  (cur_beat),
        .mask_i  (cur_mask),
        .order_i (cur_order),
        .col_o   (col_o)
    );
endmodule

// File: rtl/burst_colgen_chk.sv
module burst_colgen_chk #(
    parameter int COL_W  = 9,
    parameter int BANK_W = 1,
    parameter int LOW_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              adv_i,
    input logic [COL_W-1:0]  col_o,
    input logic [BANK_W-1:0] bank_o,
    input logic              valid_o,
    input logic              last_o
);
    // R2: a load always opens a burst
    p_load_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> valid_o);

    // R2: bank holds while no load
    p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(bank_o));

    // R5: bits above the burst field stay fixed without a load
    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !load_i) |=> $stable(col_o[COL_W-1:LOW_W]));

    // R6: no advance and no load freezes the beat
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !adv_i && !load_i) |=> ($stable(col_o) && $stable(last_o) && valid_o));

    // R7: last only inside a burst
    p_last_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R7: advancing past the final beat ends the burst
    p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && adv_i && !load_i) |=> !valid_o);

    // R9: idle stays idle without a load
    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !load_i) |=> !valid_o);
endmodule

bind sdram_burst_colgen burst_colgen_chk #(
    .COL_W(COL_W), .BANK_W(BANK_W), .LOW_W(LOW_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .adv_i   (adv_i),
    .col_o   (col_o),
    .bank_o  (bank_o),
    .valid_o (valid_o),
    .last_o  (last_o)
);

// File: tb/sim_sdram_burst_colgen.sv
module sim_sdram_burst_colgen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [0:0] bank_i = '0;
    logic [1:0] len_code_i = '0;
    logic       order_i = 1'b0;
    logic       adv_i = 1'b0;
    logic [8:0] col_o;
    logic [0:0] bank_o;
    logic       valid_o;
    logic       last_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    bit       m_valid = 0;
    bit [8:0] m_start = '0;
    bit [2:0] m_beat  = '0;
    int       m_len   = 1;
    bit       m_ord   = 0;
    bit       m_bank  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_burst_colgen u0 (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .start_col_i(start_col_i),
        .bank_i(bank_i), .len_code_i(len_code_i), .order_i(order_i), .adv_i(adv_i),
        .col_o(col_o), .bank_o(bank_o), .valid_o(valid_o), .last_o(last_o)
    );

    function automatic bit [8:0] exp_col(bit [8:0] st, bit [2:0] bt, int len, bit od);
        bit [8:0] msk;
        bit [2:0] off;
        msk = 9'(len - 1);
        off = od ? (st[2:0] ^ bt) : (st[2:0] + bt);
        return (st & ~msk) | ({6'b0, off} & msk);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        bit exp_last;
        exp_last = m_valid && (int'(m_beat) == m_len - 1);
        chk(valid_o == m_valid, "R7 valid", int'(valid_o), int'(m_valid));
        chk(last_o == exp_last, "R7 last", int'(last_o), int'(exp_last));
        if (m_valid) begin
            chk(col_o == exp_col(m_start, m_beat, m_len, m_ord),
                m_ord ? "R4 col" : "R3 col", int'(col_o),
                int'(exp_col(m_start, m_beat, m_len, m_ord)));
            chk(bank_o == m_bank, "R2 bank", int'(bank_o), int'(m_bank));
        end
    endtask

    task automatic drive(input bit ld, input bit [8:0] sc, input bit bk,
                         input bit [1:0] lc, input bit od, input bit av);
        load_i = ld; start_col_i = sc; bank_i = bk;
        len_code_i = lc; order_i = od; adv_i = av;
        if (ld) begin
            m_valid = 1; m_start = sc; m_bank = bk;
            m_len = 1 << lc; m_ord = od; m_beat = '0;
        end else if (m_valid && av) begin
            if (int'(m_beat) == m_len - 1) m_valid = 0;
            else m_beat = m_beat + 3'd1;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit [8:0] seq8 [8];
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(valid_o == 0 && last_o == 0, "R1 flags", int'({valid_o, last_o}), 0);
        chk(col_o == 0 && bank_o == 0, "R1 col/bank", int'(col_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o == 0 && col_o == 0, "R1 after release", int'(col_o), 0);

        // R9: advance while idle does nothing
        drive(0, 9'h0, 0, 2'd3, 0, 1);
        drive(0, 9'h0, 0, 2'd3, 0, 1);
        chk(valid_o == 0, "R9 idle adv", int'(valid_o), 0);

        // R2 R3 R5: sequential length 8 from 0x1AD gives low bits 5,6,7,0,1,2,3,4
        seq8 = '{9'h1AD, 9'h1AE, 9'h1AF, 9'h1A8, 9'h1A9, 9'h1AA, 9'h1AB, 9'h1AC};
        drive(1, 9'h1AD, 1, 2'd3, 0, 0);
        chk(col_o == seq8[0], "R2 first beat", int'(col_o), int'(seq8[0]));
        for (int i = 1; i < 8; i++) begin
            drive(0, 9'h0, 0, 2'd0, 0, 1);
            chk(col_o == seq8[i], "R3 directed seq8", int'(col_o), int'(seq8[i]));
        end
        chk(last_o == 1, "R7 last at beat 7", int'(last_o), 1);
        drive(0, 9'h0, 0, 2'd0, 0, 1);
        chk(valid_o == 0, "R7 end of burst", int'(valid_o), 0);

        // R4 R10-style order select: interleaved length 4 from 0x0F6 -> 6,7,4,5
        drive(1, 9'h0F6, 0, 2'd2, 1, 0);
        drive(0, 9'h0, 0, 2'd0, 0, 1);
        chk(col_o == 9'h0F7, "R4 beat1", int'(col_o), 9'h0F7);
        drive(0, 9'h0, 0, 2'd0, 0, 1);
        chk(col_o == 9'h0F4, "R4 beat2", int'(col_o), 9'h0F4);
        // R6: hold without advance
        drive(0, 9'h0, 0, 2'd0, 0, 0);
        drive(0, 9'h0, 0, 2'd0, 0, 0);
        chk(col_o == 9'h0F4 && valid_o, "R6 hold", int'(col_o), 9'h0F4);

        // R8: load mid-burst restarts, even with advance high
        drive(1, 9'h033, 1, 2'd1, 0, 1);
        chk(col_o == 9'h033 && bank_o == 1, "R8 restart", int'(col_o), 9'h033);
        drive(0, 9'h0, 0, 2'd0, 0, 1);
        chk(col_o == 9'h032 && last_o, "R5 len2 wrap", int'(col_o), 9'h032);

        // R5: length 1 is last immediately
        drive(1, 9'h155, 0, 2'd0, 1, 0);
        chk(last_o == 1 && col_o == 9'h155, "R5 len1", int'(col_o), 9'h155);
        drive(0, 9'h0, 0, 2'd0, 0, 1);
        chk(valid_o == 0, "R7 len1 end", int'(valid_o), 0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit ld;
            ld = ($urandom % 6) == 0;
            drive(ld, 9'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
                  ($urandom % 4) != 0);
        end
        finish_run();
    end
endmodule